// File: doc/BRIEF.md
# IDE Boot Sector Loader

A hardware sequencer that brings a boot loader in from an IDE or CompactFlash device. It needs no processor. After a start pulse it pulses the device reset line and waits for the device to settle. It then polls the status register until the device reports ready, and programs the task-file registers for a logical-block read of a fixed number of sectors starting at block 1.

It waits for the data request and reads every 16-bit word of the transfer. Each word leaves the block as two byte writes on a simple memory port. The block then reads the final status and checks the first loaded byte against a boot signature. The outcome is one of four result flags.

The block drives the device's control lines directly: three address bits, two active-low chip selects, active-low read and write strobes, and reset. The 16-bit data bus is bidirectional. Register writes use only its low byte. Every delay, strobe width and timeout is a parameter counted in system clocks.

Top module: `ide_boot_loader`

## Requirements
- R1: A `start` pulse sampled while idle asserts `ide_rst_n` low for exactly RESET_CYC clocks. A `start` pulse during a run is ignored: it causes no second reset pulse and leaves the outcome unchanged.
- R2: The device register address is the vector {cs1, cs0, a2, a1, a0}. The chip selects leave the block inverted on `ide_cs_n[1]` (cs1) and `ide_cs_n[0]` (cs0). An access follows four steps. First the address is driven alone for one clock. Then the strobe is low for STROBE_CYC clocks with the address stable. Then the address is held for HOLD_CYC clocks after the strobe rises. Finally all lines are released (`ide_cs_n`=11). Read and write strobes are never low together.
- R3: The first status-read strobe falls no sooner than SETTLE_CYC clocks after `ide_rst_n` returns high.
- R4: Status at address 0x0F is accepted as ready only when (status & 0xC0) == 0x40. A value such as 0xC0 is rejected. After POLL_INNER×POLL_OUTER rejected reads the run ends with `not_ready`, and no memory write takes place.
- R5: Once the device is ready, exactly six register writes follow, in this order: 0x0E←0xE0, 0x0B←0x01, 0x0C←0x00, 0x0D←0x00, 0x0A←SECTORS, 0x0F←0x20.
- R6: After the command the block polls status again and starts data reads only when (status & 0x88) == 0x08. A value such as 0x88 is rejected. The same timeout as R4 applies.
- R7: The block makes SECTORS×256 reads of address 0x08. For word k, the low byte is written to LOAD_BASE+2k and the high byte to LOAD_BASE+2k+1. Each byte takes one `mem_we` cycle, and exactly SECTORS×512 bytes are written.
- R8: After the last word the block reads status once more. If bit 0 is set, the result is `rw_error`.
- R9: With no error, the result is `done` if the byte written at LOAD_BASE equals BOOT_SIG and `bad_sig` otherwise.
- R10: After reset, `busy` and all four result flags are low and every device line is inactive. During a run `busy` is high and the result flags are low. Afterwards exactly one result flag is high, and it holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a boot load (sampled while idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Load finished, signature good |
| not_ready | output | 1 | Status polling timed out |
| rw_error | output | 1 | Final status had its error bit set |
| bad_sig | output | 1 | First loaded byte differs from BOOT_SIG |
| ide_addr | output | 3 | Device register address bits a2..a0 |
| ide_cs_n | output | 2 | Active-low chip selects {cs1, cs0} |
| ide_rd_n | output | 1 | Active-low read strobe |
| ide_wr_n | output | 1 | Active-low write strobe |
| ide_rst_n | output | 1 | Active-low device reset |
| ide_data | inout | 16 | Device data bus |
| mem_addr | output | 16 | Byte address of the load write |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | One-cycle byte write enable |

## Verification
Reset goes low in the clock after `start` is sampled. The first strobe comes SETTLE_CYC+1 clocks after reset is released. Each word yields two consecutive byte writes, and the result flags appear in the same clock that `busy` falls. The bench samples every output on the falling clock edge. It counts reset cycles, settle cycles and byte writes as they happen, and it judges results only once `busy` has fallen, so no check depends on guessing a completion cycle. The device model answers each access when the strobe rises, during the address hold, so the status sequence it returns is tied to the read count and not to time.

// File: rtl/ide_boot_loader.sv
module ide_boot_loader #(
  parameter int RESET_CYC = 600,
  parameter int SETTLE_CYC = 150000,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC = 2,
  parameter int POLL_INNER = 128,
  parameter int POLL_OUTER = 255,
  parameter int SECTORS = 12,
  parameter logic [15:0] LOAD_BASE = 16'h0100,
  parameter logic [7:0] BOOT_SIG = 8'h31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        not_ready,
  output logic        rw_error,
  output logic        bad_sig,
  output logic [2:0]  ide_addr,
  output logic [1:0]  ide_cs_n,
  output logic        ide_rd_n,
  output logic        ide_wr_n,
  output logic        ide_rst_n,
  inout  wire  [15:0] ide_data,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we
);
  localparam int WORDS = SECTORS * 256;
  localparam int WW = $clog2(WORDS + 1);
  localparam int CW = $clog2(SETTLE_CYC + RESET_CYC + STROBE_CYC + HOLD_CYC + 2);
  localparam int IW = $clog2(POLL_INNER + 1);
  localparam int OW = $clog2(POLL_OUTER + 1);
  localparam logic [4:0] R_DATA = 5'h08, R_CNT = 5'h0A, R_SEC = 5'h0B, R_CYL = 5'h0C,
                         R_CYH = 5'h0D, R_DH = 5'h0E, R_CMD = 5'h0F;

  typedef enum logic [3:0] {IDLE, RST, SETTLE, ACC, POLL, TF, WLO, WHI, FIN} st_t;
  typedef enum logic [1:0] {P_SET, P_STB, P_HLD, P_REL} ph_t;

  st_t st, ret, nret;
  ph_t ph;
  logic [CW-1:0] cnt;
  logic [4:0] areg, nreg;
  logic awr, nwr, go, ok, drq_mode;
  logic [7:0] awd, nwd, first;
  logic [15:0] rdat, ptr;
  logic [IW-1:0] inner;
  logic [OW-1:0] outer;
  logic [2:0] tf_i;
  logic [WW-1:0] words;
  logic [3:0] res;

  function automatic logic [12:0] tf_entry(input logic [2:0] i);
    case (i)
      3'd0: return {R_DH, 8'hE0};
      3'd1: return {R_SEC, 8'h01};
      3'd2: return {R_CYL, 8'h00};
      3'd3: return {R_CYH, 8'h00};
      3'd4: return {R_CNT, 8'(SECTORS)};
      default: return {R_CMD, 8'h20};
    endcase
  endfunction

  wire act = (st == ACC) && (ph != P_REL);
  wire last_try = (inner == IW'(POLL_INNER - 1)) && (outer == OW'(POLL_OUTER - 1));

  assign busy = (st != IDLE);
  assign {bad_sig, rw_error, not_ready, done} = res;
  assign ide_rst_n = (st != RST);
  assign ide_cs_n = act ? ~areg[4:3] : 2'b11;
  assign ide_addr = act ? areg[2:0] : 3'b000;
  assign ide_rd_n = !(st == ACC && ph == P_STB && !awr);
  assign ide_wr_n = !(st == ACC && ph == P_STB && awr);
  assign ide_data = (act && awr) ? {8'h00, awd} : 16'hzzzz;
  assign mem_we = (st == WLO) || (st == WHI);
  assign mem_addr = ptr;
  assign mem_wdata = (st == WLO) ? rdat[7:0] : rdat[15:8];
  assign ok = drq_mode ? ((rdat[7:0] & 8'h88) == 8'h08) : ((rdat[7:0] & 8'hC0) == 8'h40);

  always_comb begin
    go = 1'b0; nreg = R_CMD; nwr = 1'b0; nwd = 8'h00; nret = POLL;
    case (st)
      SETTLE: go = (cnt == CW'(SETTLE_CYC - 1));
      POLL: begin
        if (ok && drq_mode) begin go = 1'b1; nreg = R_DATA; nret = WLO; end
        else if (!ok) go = !last_try;
      end
      TF: begin
        go = 1'b1;
        if (tf_i != 3'd6) begin nwr = 1'b1; nret = TF; {nreg, nwd} = tf_entry(tf_i); end
      end
      WHI: begin
        go = 1'b1;
        if (words == WW'(WORDS - 1)) nret = FIN;
        else begin nreg = R_DATA; nret = WLO; end
      end
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ret <= IDLE; ph <= P_SET; cnt <= '0; areg <= '0; awr <= 1'b0;
      awd <= '0; rdat <= '0; ptr <= LOAD_BASE; inner <= '0; outer <= '0;
      drq_mode <= 1'b0; tf_i <= '0; words <= '0; first <= '0; res <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st <= RST; cnt <= '0; res <= '0; ptr <= LOAD_BASE;
          inner <= '0; outer <= '0; drq_mode <= 1'b0;
        end
        RST: if (cnt == CW'(RESET_CYC - 1)) begin st <= SETTLE; cnt <= '0; end
             else cnt <= cnt + 1'b1;
        SETTLE: cnt <= cnt + 1'b1;
        ACC: case (ph)
          P_SET: begin ph <= P_STB; cnt <= '0; end
          P_STB: if (cnt == CW'(STROBE_CYC - 1)) begin
                   ph <= P_HLD; cnt <= '0;
                   if (!awr) rdat <= ide_data;
                 end else cnt <= cnt + 1'b1;
          P_HLD: if (cnt == CW'(HOLD_CYC - 1)) ph <= P_REL;
                 else cnt <= cnt + 1'b1;
          default: st <= ret;
        endcase
        POLL: begin
          if (ok && drq_mode) words <= '0;
          else if (ok) begin st <= TF; tf_i <= '0; end
          else if (last_try) begin res <= 4'b0010; st <= IDLE; end
          else if (inner == IW'(POLL_INNER - 1)) begin inner <= '0; outer <= outer + 1'b1; end
          else inner <= inner + 1'b1;
        end
        TF: if (tf_i != 3'd6) tf_i <= tf_i + 1'b1;
            else begin drq_mode <= 1'b1; inner <= '0; outer <= '0; end
        WLO: begin
          ptr <= ptr + 16'd1; st <= WHI;
          if (words == '0) first <= rdat[7:0];
        end
        WHI: begin ptr <= ptr + 16'd1; words <= words + 1'b1; end
        FIN: begin
          st <= IDLE;
          res <= rdat[0] ? 4'b0100 : ((first == BOOT_SIG) ? 4'b0001 : 4'b1000);
        end
        default: st <= IDLE;
      endcase
      if (go) begin
        st <= ACC; ph <= P_SET; cnt <= '0;
        areg <= nreg; awr <= nwr; awd <= nwd; ret <= nret;
      end
    end
  end

  // R10
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(res));
  // R10
  busy_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (res == 4'b0000));
  // R2
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n || !ide_wr_n) |-> (ide_cs_n != 2'b11));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!ide_rd_n && !ide_wr_n));
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n && $past(!ide_rd_n)) |-> ($stable(ide_addr) && $stable(ide_cs_n)));
  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ide_rd_n) || $fell(ide_wr_n)) |-> ($past(ide_cs_n) == ide_cs_n));
  // R7
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  // R1
  dev_reset_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !ide_rst_n |-> busy);
endmodule

// File: tb/ide_boot_loader_tb_top.sv
`timescale 1ns/1ps
module ide_boot_loader_tb_top;
  localparam int RC = 6, SC = 20, STB = 2, HLD = 1, PI = 3, PO = 4, NSEC = 12;
  localparam int WORDS = NSEC * 256, NBYTES = WORDS * 2;
  // fields: [31:24] busy polls, [23:16] first byte, [15:8] final error bit, [7:0] expected {bad,rw,nr,done}
  localparam logic [31:0] VEC [5] = '{
    {8'd2,  8'h31, 8'd0, 8'h01},
    {8'd0,  8'h30, 8'd0, 8'h08},
    {8'd1,  8'h31, 8'd1, 8'h04},
    {8'd12, 8'h31, 8'd0, 8'h02},
    {8'd11, 8'h31, 8'd0, 8'h01}
  };
  localparam logic [4:0] TF_REG [6] = '{5'h0E, 5'h0B, 5'h0C, 5'h0D, 5'h0A, 5'h0F};
  localparam logic [7:0] TF_VAL [6] = '{8'hE0, 8'h01, 8'h00, 8'h00, 8'h0C, 8'h20};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start;
  logic busy, done, not_ready, rw_error, bad_sig, ide_rd_n, ide_wr_n, ide_rst_n, mem_we;
  logic [2:0] ide_addr;
  logic [1:0] ide_cs_n;
  logic [15:0] mem_addr, dev_word;
  logic [7:0] mem_wdata;
  wire [15:0] ide_data;

  ide_boot_loader #(.RESET_CYC(RC), .SETTLE_CYC(SC), .STROBE_CYC(STB), .HOLD_CYC(HLD),
    .POLL_INNER(PI), .POLL_OUTER(PO), .SECTORS(NSEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .not_ready(not_ready),
    .rw_error(rw_error), .bad_sig(bad_sig), .ide_addr(ide_addr), .ide_cs_n(ide_cs_n),
    .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_rst_n(ide_rst_n), .ide_data(ide_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we));

  int run_id = 0;
  int busy_cfg = 0;
  logic [7:0] sig_cfg = 8'h31;
  logic err_cfg = 1'b0;
  wire [4:0] cur_reg = {~ide_cs_n, ide_addr};

  function automatic logic [15:0] dw(input int k, input logic [7:0] s);
    logic [7:0] lo, hi;
    lo = (k == 0) ? s : (8'(k) ^ 8'h5A);
    hi = 8'(k * 3) ^ 8'(k >> 8);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] st_val(input bit cmd, input int pre, input int post,
                                        input int wr, input int bcfg, input logic e);
    if (!cmd) return (pre < bcfg) ? 8'hC0 : 8'h50;
    if (post < 2) return 8'h88;
    if (wr < WORDS) return 8'h58;
    return {7'b0101000, e};
  endfunction

  // device model: reads
  int r_seen = -1, pre_st = 0, post_st = 0, words_rd = 0, cmd_base = 0, first_data_post = -1;
  int cmd_total = 0;
  assign dev_word = (cur_reg == 5'h08) ? dw(words_rd, sig_cfg)
                  : {8'h00, st_val(cmd_total > cmd_base, pre_st, post_st, words_rd, busy_cfg, err_cfg)};
  assign ide_data = !ide_rd_n ? dev_word : 16'hzzzz;

  always @(posedge ide_rd_n or run_id) begin
    if (run_id != r_seen) begin
      r_seen = run_id; pre_st = 0; post_st = 0; words_rd = 0; cmd_base = cmd_total; first_data_post = -1;
    end else if (cur_reg == 5'h0F) begin
      if (cmd_total > cmd_base) post_st++; else pre_st++;
    end else if (cur_reg == 5'h08) begin
      if (words_rd == 0) first_data_post = post_st;
      words_rd++;
    end
  end

  // device model: writes
  int w_seen = -1, tf_n = 0;
  logic [4:0] tf_reg [8];
  logic [7:0] tf_val [8];
  always @(posedge ide_wr_n or run_id) begin
    if (run_id != w_seen) begin
      w_seen = run_id; tf_n = 0;
    end else begin
      if (tf_n < 8) begin tf_reg[tf_n] = cur_reg; tf_val[tf_n] = ide_data[7:0]; end
      tf_n++;
      if (cur_reg == 5'h0F) cmd_total++;
    end
  end

  // port monitor
  int m_seen = -1, rst_low = 0, rst_pulses = 0, gap = 0, bytes = 0, merr = 0, cyc = 0, fails = 0, checks = 0;
  bit first_rd = 0, prev_rst = 1;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
    if (run_id != m_seen) begin
      m_seen = run_id; rst_low = 0; rst_pulses = 0; gap = 0; bytes = 0; merr = 0; first_rd = 0;
    end
    if (!ide_rst_n) rst_low++;
    if (prev_rst && !ide_rst_n) rst_pulses++;
    prev_rst = ide_rst_n;
    if (ide_rst_n && rst_low > 0 && !first_rd) begin
      if (!ide_rd_n) first_rd = 1; else gap++;
    end
    if (mem_we) begin
      logic [15:0] w;
      w = dw(bytes / 2, sig_cfg);
      if (mem_addr != 16'(16'h0100 + bytes) || mem_wdata != ((bytes % 2) ? w[15:8] : w[7:0])) merr++;
      bytes++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] code();
    return {bad_sig, rw_error, not_ready, done};
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && code() == 4'b0000, "R10 reset result", {busy, code()}, 0);
    chk(ide_rst_n && ide_rd_n && ide_wr_n && ide_cs_n == 2'b11 && !mem_we, "R10 reset lines",
        {ide_rst_n, ide_rd_n, ide_wr_n, ide_cs_n, mem_we}, 6'b111110);

    for (int v = 0; v < 5; v++) begin
      logic [3:0] exp;
      int lim;
      busy_cfg = int'(VEC[v][31:24]); sig_cfg = VEC[v][23:16]; err_cfg = VEC[v][8];
      exp = VEC[v][3:0];
      run_id++;
      @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      if (v == 0) begin
        repeat (60) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // R1: ignored while busy
      end
      lim = 0;
      while (busy && lim < 40000) begin @(negedge clk); lim++; end
      chk(lim < 40000, "R10 run finished", lim, 40000);
      case (exp)
        4'b0001: chk(code() == exp, "R9 done", code(), exp);
        4'b1000: chk(code() == exp, "R9 bad_sig", code(), exp);
        4'b0100: chk(code() == exp, "R8 rw_error", code(), exp);
        default: chk(code() == exp, "R4 not_ready", code(), exp);
      endcase
      chk(rst_low == RC, "R1 reset width", rst_low, RC);
      chk(rst_pulses == 1, "R1 single reset pulse", rst_pulses, 1);
      chk(gap >= SC, "R3 settle before first poll", gap, SC);
      if (exp == 4'b0010) begin
        chk(pre_st == PI * PO, "R4 poll count at timeout", pre_st, PI * PO);
        chk(bytes == 0, "R7 no bytes after timeout", bytes, 0);
        chk(tf_n == 0, "R5 no register writes after timeout", tf_n, 0);
      end else begin
        chk(pre_st == busy_cfg + 1, "R4 ready mask polls", pre_st, busy_cfg + 1);
        chk(tf_n == 6, "R5 write count", tf_n, 6);
        for (int i = 0; i < 6; i++)
          chk(tf_reg[i] == TF_REG[i] && tf_val[i] == TF_VAL[i], "R5 write order",
              {tf_reg[i], tf_val[i]}, {TF_REG[i], TF_VAL[i]});
        chk(first_data_post == 3, "R6 data request mask polls", first_data_post, 3);
        chk(words_rd == WORDS, "R7 word reads", words_rd, WORDS);
        chk(bytes == NBYTES, "R7 byte writes", bytes, NBYTES);
        chk(merr == 0, "R7 byte address/data", merr, 0);
      end
      repeat (20) @(negedge clk);
      chk(!busy && code() == exp, "R10 result held", code(), exp);
    end

    // R10: reset in the middle of a run clears everything
    busy_cfg = 0; run_id++;
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy, "R10 busy during run", busy, 1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(!busy && code() == 4'b0000 && ide_rst_n && ide_cs_n == 2'b11, "R10 mid-run reset",
        {busy, code(), ide_rst_n, ide_cs_n}, 8'b00000111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule